// File: doc/BRIEF.md
# Incremental Conic Curve Stepper

This block is a digital differential analyser that walks a beam position along a conic curve, one point per iteration. Each axis has three parts. The first is an integer position. The second is a fractional accumulator. The third is a signed rate, which is added into that accumulator on every iteration. When the accumulator overflows or underflows, it moves the other axis: that axis's position steps by one, and that axis's rate gains or loses a curvature constant. Because each axis drives the other, the pair traces ellipses and circles when the two curvatures have opposite signs. They trace straight lines when both curvatures are zero, and hyperbolas when both curvatures have the same sign. Position and accumulator together act as one fixed-point value. The accumulator is the fraction and is `FRAC_W` bits wide.

The order of the arithmetic is fixed. The X accumulator is updated first, and its wrap adjusts the Y rate. The Y accumulator is updated second and uses that freshly adjusted Y rate. Its wrap then adjusts the X rate. Both stages are evaluated combinationally, so one full ordered iteration completes per accepted clock. The per-axis state is initialised by a single-cycle load pulse. The `run_en` input enables iterations.

Each iteration produces an output item: the new X and Y positions and four step strobes. Output uses a valid/ready handshake. An item is held on the ports while `out_valid` is high and `out_ready` is low. During that time no new iteration starts, so back-pressure stalls the curve without losing a point. An item is consumed on any clock edge where both `out_valid` and `out_ready` are high. An iteration is taken on a clock edge where `run_en` is high, `start_load` is low, and either `out_valid` is low or `out_ready` is high.

Top module: `conic_dda`

## Requirements
- R1: After reset, `out_valid` is 0, both positions are 0 and all four step strobes are 0.
- R2: A `start_load` pulse copies the initial values into the position, accumulator and rate registers and captures both curvatures. The loaded positions appear on `x_pos`/`y_pos` one cycle later, with `out_valid` and all strobes at 0. A load takes priority over an iteration in the same cycle.
- R3: Each iteration first forms S = X accumulator + X rate. The accumulator is unsigned, `FRAC_W` bits; the rate is two's complement, `INC_W` bits. If S >= 2^FRAC_W, the Y rate gains the Y curvature, `y_pos` increments and `y_up` is 1. If S < 0, the Y rate loses the Y curvature, `y_pos` decrements and `y_dn` is 1. The X accumulator keeps the low `FRAC_W` bits of S. Rates wrap modulo 2^INC_W and positions wrap modulo 2^INT_W.
- R4: The Y accumulator then gains the Y rate as already updated in the same iteration. A carry adds the X curvature to the X rate, increments `x_pos` and sets `x_up`. A borrow subtracts it, decrements `x_pos` and sets `x_dn`.
- R5: An iteration takes place on a clock edge where `run_en` is high, `start_load` is low, and `out_valid` is low or `out_ready` is high. Its result appears one cycle later with `out_valid` high. Every presented item comes from exactly one iteration.
- R6: While `out_valid` is 1 and `out_ready` is 0, the positions, strobes and `out_valid` are held and no iteration occurs, even with `run_en` high.
- R7: With `run_en` low, no iteration occurs and the positions are held. `out_valid` falls after the pending item is accepted.
- R8: With both curvatures 0, the rates are constant. After N iterations from zero accumulators, `y_pos` = y0 + floor(N·xrate / 2^FRAC_W) and `x_pos` = x0 + floor(N·yrate / 2^FRAC_W).
- R9: With curvatures of opposite sign (X curvature negative, Y curvature positive), the path is a closed curve. After moving at least 8 positions away from its start point, it comes back to within 2 positions of that point on both axes.
- R10: With both curvatures positive, the path bends away. After 300 iterations from rest on X with Y rate 64, `x_pos` exceeds the straight-line value 18 and `y_pos` is above its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_load | input | 1 | Load initial state and curvatures |
| run_en | input | 1 | Enable iterations |
| ld_x_pos | input | INT_W | Initial X position |
| ld_y_pos | input | INT_W | Initial Y position |
| ld_x_frac | input | FRAC_W | Initial X accumulator |
| ld_y_frac | input | FRAC_W | Initial Y accumulator |
| ld_x_rate | input | INC_W | Initial X rate, signed |
| ld_y_rate | input | INC_W | Initial Y rate, signed |
| ld_x_curv | input | INC_W | X curvature, signed |
| ld_y_curv | input | INC_W | Y curvature, signed |
| out_valid | output | 1 | Output item present |
| out_ready | input | 1 | Consumer accepts the item |
| x_pos | output | INT_W | X position |
| y_pos | output | INT_W | Y position |
| x_up | output | 1 | X stepped up in this item |
| x_dn | output | 1 | X stepped down in this item |
| y_up | output | 1 | Y stepped up in this item |
| y_dn | output | 1 | Y stepped down in this item |

## Verification
A wrong position register shows at the ports on the item that follows the fault, as a position that disagrees with the step strobes. A wrong accumulator or rate stays hidden. It appears only as strobes that come early, come late or are missing, possibly many iterations later. For that reason every accepted item is compared with an ordered reference model. A closed circle of radius about 16 is run for several revolutions. Any error in the update order, or in the use of the freshly updated Y rate, then shows within one revolution (a few hundred iterations) as drift away from the start point.

// File: rtl/dda_pkg.sv
package dda_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DN   = 2'b10
  } step_e;
endpackage

// File: rtl/dda_wrap_add.sv
// Adds a signed rate into an unsigned fractional accumulator and reports the wrap.
module dda_wrap_add
  import dda_pkg::*;
#(
  parameter int FRAC_W = 10,
  parameter int INC_W  = 12
) (
  input  logic [FRAC_W-1:0]       frac_i,
  input  logic signed [INC_W-1:0] rate_i,
  output logic [FRAC_W-1:0]       frac_o,
  output step_e                   step_o
);
  localparam int SUM_W = INC_W + 1;

  logic signed [SUM_W-1:0] sum;
  logic carry, borrow;

  assign sum    = $signed({{(SUM_W-FRAC_W){1'b0}}, frac_i}) + $signed({rate_i[INC_W-1], rate_i});
  assign borrow = sum[SUM_W-1];
  assign carry  = !sum[SUM_W-1] && (|sum[SUM_W-2:FRAC_W]);
  assign frac_o = sum[FRAC_W-1:0];

  always_comb begin
    if (carry)       step_o = STEP_UP;
    else if (borrow) step_o = STEP_DN;
    else             step_o = STEP_NONE;
  end
endmodule

// File: rtl/dda_cross_update.sv
// Applies a wrap event from one axis to the other axis's rate and position.
module dda_cross_update
  import dda_pkg::*;
#(
  parameter int INT_W = 16,
  parameter int INC_W = 12
) (
  input  step_e                   step_i,
  input  logic signed [INC_W-1:0] rate_i,
  input  logic signed [INC_W-1:0] curv_i,
  input  logic [INT_W-1:0]        pos_i,
  output logic signed [INC_W-1:0] rate_o,
  output logic [INT_W-1:0]        pos_o
);
  localparam logic [INT_W-1:0] ONE = {{(INT_W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (step_i)
      STEP_UP: begin
        rate_o = rate_i + curv_i;
        pos_o  = pos_i + ONE;
      end
      STEP_DN: begin
        rate_o = rate_i - curv_i;
        pos_o  = pos_i - ONE;
      end
      default: begin
        rate_o = rate_i;
        pos_o  = pos_i;
      end
    endcase
  end
endmodule

// File: rtl/conic_dda.sv
module conic_dda
  import dda_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 10,
  parameter int INC_W  = FRAC_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_load,
  input  logic                    run_en,
  input  logic [INT_W-1:0]        ld_x_pos,
  input  logic [INT_W-1:0]        ld_y_pos,
  input  logic [FRAC_W-1:0]       ld_x_frac,
  input  logic [FRAC_W-1:0]       ld_y_frac,
  input  logic signed [INC_W-1:0] ld_x_rate,
  input  logic signed [INC_W-1:0] ld_y_rate,
  input  logic signed [INC_W-1:0] ld_x_curv,
  input  logic signed [INC_W-1:0] ld_y_curv,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [INT_W-1:0]        x_pos,
  output logic [INT_W-1:0]        y_pos,
  output logic                    x_up,
  output logic                    x_dn,
  output logic                    y_up,
  output logic                    y_dn
);
  localparam int NAX = 2;  // axis 0 = X, axis 1 = Y
  localparam logic [INT_W-1:0] ONE = {{(INT_W-1){1'b0}}, 1'b1};

  // Per-axis state
  logic [FRAC_W-1:0]       frac_q  [NAX];
  logic signed [INC_W-1:0] rate_q  [NAX];
  logic signed [INC_W-1:0] curv_q  [NAX];
  logic [INT_W-1:0]        pos_q   [NAX];
  step_e                   step_q  [NAX];
  logic                    valid_q;

  // Load sources and next-state values, per axis
  logic [FRAC_W-1:0]       frac_ld [NAX];
  logic signed [INC_W-1:0] rate_ld [NAX];
  logic signed [INC_W-1:0] curv_ld [NAX];
  logic [INT_W-1:0]        pos_ld  [NAX];
  logic [FRAC_W-1:0]       frac_nx [NAX];
  logic signed [INC_W-1:0] rate_nx [NAX];
  logic [INT_W-1:0]        pos_nx  [NAX];
  step_e                   step_nx [NAX];

  assign frac_ld[0] = ld_x_frac;  assign frac_ld[1] = ld_y_frac;
  assign rate_ld[0] = ld_x_rate;  assign rate_ld[1] = ld_y_rate;
  assign curv_ld[0] = ld_x_curv;  assign curv_ld[1] = ld_y_curv;
  assign pos_ld[0]  = ld_x_pos;   assign pos_ld[1]  = ld_y_pos;

  logic fire;
  assign fire = run_en && !start_load && (!valid_q || out_ready);

  // Stage 1: X accumulator, its wrap moves Y
  logic [FRAC_W-1:0]       x_frac_s1;
  step_e                   y_step_s1;
  logic signed [INC_W-1:0] y_rate_s1;
  logic [INT_W-1:0]        y_pos_s1;

  dda_wrap_add #(.FRAC_W(FRAC_W), .INC_W(INC_W)) u_add_x (
    .frac_i(frac_q[0]), .rate_i(rate_q[0]), .frac_o(x_frac_s1), .step_o(y_step_s1)
  );

  dda_cross_update #(.INT_W(INT_W), .INC_W(INC_W)) u_cross_y (
    .step_i(y_step_s1), .rate_i(rate_q[1]), .curv_i(curv_q[1]), .pos_i(pos_q[1]),
    .rate_o(y_rate_s1), .pos_o(y_pos_s1)
  );

  // Stage 2: Y accumulator uses the freshly updated Y rate, its wrap moves X
  logic [FRAC_W-1:0]       y_frac_s2;
  step_e                   x_step_s2;
  logic signed [INC_W-1:0] x_rate_s2;
  logic [INT_W-1:0]        x_pos_s2;

  dda_wrap_add #(.FRAC_W(FRAC_W), .INC_W(INC_W)) u_add_y (
    .frac_i(frac_q[1]), .rate_i(y_rate_s1), .frac_o(y_frac_s2), .step_o(x_step_s2)
  );

  dda_cross_update #(.INT_W(INT_W), .INC_W(INC_W)) u_cross_x (
    .step_i(x_step_s2), .rate_i(rate_q[0]), .curv_i(curv_q[0]), .pos_i(pos_q[0]),
    .rate_o(x_rate_s2), .pos_o(x_pos_s2)
  );

  assign frac_nx[0] = x_frac_s1;  assign frac_nx[1] = y_frac_s2;
  assign rate_nx[0] = x_rate_s2;  assign rate_nx[1] = y_rate_s1;
  assign pos_nx[0]  = x_pos_s2;   assign pos_nx[1]  = y_pos_s1;
  assign step_nx[0] = x_step_s2;  assign step_nx[1] = y_step_s1;

  // Register bank, one copy per axis
  for (genvar a = 0; a < NAX; a++) begin : g_axis
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frac_q[a] <= '0;
        rate_q[a] <= '0;
        curv_q[a] <= '0;
        pos_q[a]  <= '0;
        step_q[a] <= STEP_NONE;
      end else if (start_load) begin
        frac_q[a] <= frac_ld[a];
        rate_q[a] <= rate_ld[a];
        curv_q[a] <= curv_ld[a];
        pos_q[a]  <= pos_ld[a];
        step_q[a] <= STEP_NONE;
      end else if (fire) begin
        frac_q[a] <= frac_nx[a];
        rate_q[a] <= rate_nx[a];
        pos_q[a]  <= pos_nx[a];
        step_q[a] <= step_nx[a];
      end
    end

    // R8: a zero curvature leaves the rate untouched across an iteration
    a_r8_flat_rate: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && curv_q[a] == '0) |=> (rate_q[a] == $past(rate_q[a])));
  end

  // Output handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          valid_q <= 1'b0;
    else if (start_load) valid_q <= 1'b0;
    else if (fire)       valid_q <= 1'b1;
    else if (out_ready)  valid_q <= 1'b0;
  end

  assign out_valid = valid_q;
  assign x_pos     = pos_q[0];
  assign y_pos     = pos_q[1];
  assign x_up      = (step_q[0] == STEP_UP);
  assign x_dn      = (step_q[0] == STEP_DN);
  assign y_up      = (step_q[1] == STEP_UP);
  assign y_dn      = (step_q[1] == STEP_DN);

  // Strobes agree with the actual position movement
  a_r3_y_up_moves: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (y_up == (y_pos == $past(y_pos) + ONE)));
  a_r3_y_dn_moves: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (y_dn == (y_pos == $past(y_pos) - ONE)));
  a_r4_x_up_moves: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (x_up == (x_pos == $past(x_pos) + ONE)));
  a_r4_x_dn_moves: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (x_dn == (x_pos == $past(x_pos) - ONE)));
  a_r5_valid_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start_load) |=>
      (out_valid && $stable(x_pos) && $stable(y_pos)));
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !start_load) |=> ($stable(x_pos) && $stable(y_pos)));
  a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_load |=> (!out_valid && !x_up && !x_dn && !y_up && !y_dn));
endmodule

// File: tb/conic_dda_tb.sv
`timescale 1ns/100ps
module conic_dda_tb;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 10;
  localparam int INC_W  = 12;
  localparam int FULL   = 1 << FRAC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_load = 1'b0, run_en = 1'b0, out_ready = 1'b0;
  logic [INT_W-1:0] ld_x_pos = '0, ld_y_pos = '0;
  logic [FRAC_W-1:0] ld_x_frac = '0, ld_y_frac = '0;
  logic signed [INC_W-1:0] ld_x_rate = '0, ld_y_rate = '0, ld_x_curv = '0, ld_y_curv = '0;
  logic out_valid, x_up, x_dn, y_up, y_dn;
  logic [INT_W-1:0] x_pos, y_pos;

  always #2 clk = ~clk;

  conic_dda #(.INT_W(INT_W), .FRAC_W(FRAC_W), .INC_W(INC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_load(start_load), .run_en(run_en),
    .ld_x_pos(ld_x_pos), .ld_y_pos(ld_y_pos), .ld_x_frac(ld_x_frac), .ld_y_frac(ld_y_frac),
    .ld_x_rate(ld_x_rate), .ld_y_rate(ld_y_rate), .ld_x_curv(ld_x_curv), .ld_y_curv(ld_y_curv),
    .out_valid(out_valid), .out_ready(out_ready), .x_pos(x_pos), .y_pos(y_pos),
    .x_up(x_up), .x_dn(x_dn), .y_up(y_up), .y_dn(y_dn)
  );

  typedef struct packed {
    logic [INT_W-1:0] x;
    logic [INT_W-1:0] y;
    logic xu, xd, yu, yd;
  } item_t;

  item_t sb_q[$];
  int n_tests = 0, n_fail = 0;

  // reference model state
  int mxs, mys, mxr, myr, mxi, myi, mxc, myc;
  logic [15:0] lfsr = 16'hACE1;

  // closure tracking
  bit track_on = 0, far_seen = 0, back_seen = 0;
  int sx0, sy0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int wrap_rate(input int v);
    int t;
    t = v & ((1 << INC_W) - 1);
    return (t >= (1 << (INC_W-1))) ? t - (1 << INC_W) : t;
  endfunction

  task automatic model_step(output item_t e);
    int s;
    e = '0;
    s = mxr + mxi;
    if (s >= FULL) begin myi = wrap_rate(myi + myc); mys++; e.yu = 1'b1; end
    else if (s < 0) begin myi = wrap_rate(myi - myc); mys--; e.yd = 1'b1; end
    mxr = s & (FULL-1);
    s = myr + myi;
    if (s >= FULL) begin mxi = wrap_rate(mxi + mxc); mxs++; e.xu = 1'b1; end
    else if (s < 0) begin mxi = wrap_rate(mxi - mxc); mxs--; e.xd = 1'b1; end
    myr = s & (FULL-1);
    e.x = INT_W'(mxs);
    e.y = INT_W'(mys);
  endtask

  task automatic do_load(input int xs, input int ys, input int xr, input int yr,
                         input int xi, input int yi, input int xc, input int yc);
    @(negedge clk);
    ld_x_pos = INT_W'(xs);  ld_y_pos = INT_W'(ys);
    ld_x_frac = FRAC_W'(xr); ld_y_frac = FRAC_W'(yr);
    ld_x_rate = INC_W'(xi); ld_y_rate = INC_W'(yi);
    ld_x_curv = INC_W'(xc); ld_y_curv = INC_W'(yc);
    start_load = 1'b1;
    @(negedge clk);
    start_load = 1'b0;
    mxs = xs; mys = ys; mxr = xr; myr = yr;
    mxi = wrap_rate(xi); myi = wrap_rate(yi); mxc = wrap_rate(xc); myc = wrap_rate(yc);
  endtask

  // Driver: mode 0 run and ready always, 1 random ready, 2 random run and ready
  task automatic run_iters(input int nfire, input int mode);
    int done = 0;
    item_t e;
    while (done < nfire) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_en    = (mode == 2) ? lfsr[3] : 1'b1;
      out_ready = (mode == 0) ? 1'b1 : lfsr[7];
      #0.5;
      if (run_en && (!out_valid || out_ready)) begin
        model_step(e);
        sb_q.push_back(e);
        done++;
      end
    end
    @(negedge clk);
    run_en = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R5", "every iteration presented once", 64'(sb_q.size()), 64'd0);
  endtask

  // Monitor: compares every accepted item with the scoreboard
  always @(negedge clk) begin
    item_t e;
    int dx, dy;
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R5", "item without iteration", {x_pos, y_pos}, 64'd0);
      end else begin
        e = sb_q.pop_front();
        chk({x_pos, y_pos, x_up, x_dn, y_up, y_dn} == e, "R3/R4",
            "ordered update item", 64'({x_pos, y_pos, x_up, x_dn, y_up, y_dn}), 64'(e));
        if (track_on) begin
          dx = int'($signed(x_pos)) - sx0;
          dy = int'($signed(y_pos)) - sy0;
          if (dx >= 8 || dx <= -8 || dy >= 8 || dy <= -8) far_seen = 1;
          else if (far_seen && dx <= 2 && dx >= -2 && dy <= 2 && dy >= -2) back_seen = 1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [INT_W-1:0] hx, hy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(x_pos == '0 && y_pos == '0, "R1", "positions after reset", {x_pos, y_pos}, 64'd0);
    chk({x_up, x_dn, y_up, y_dn} == 4'b0, "R1", "strobes after reset",
        64'({x_up, x_dn, y_up, y_dn}), 64'd0);

    // R2 load values appear
    do_load(100, -5, 3, 4, 10, 20, 0, 0);
    #1;
    chk(x_pos == 16'd100 && y_pos == 16'hFFFB, "R2", "loaded positions",
        {x_pos, y_pos}, {16'd100, 16'hFFFB});
    chk(out_valid == 1'b0, "R2", "out_valid after load", 64'(out_valid), 64'd0);

    // R8 straight line, R3/R4 carry and borrow
    do_load(0, 0, 0, 0, 300, -200, 0, 0);
    run_iters(50, 0);
    #1;
    chk(y_pos == 16'd14, "R8", "line y after 50", 64'(y_pos), 64'd14);
    chk(x_pos == 16'hFFF6, "R8", "line x after 50", 64'(x_pos), 64'hFFF6);

    // R6 back-pressure stall with run high
    do_load(7, 9, 500, 500, 700, 700, 5, 5);
    @(negedge clk);
    run_en = 1'b1; out_ready = 1'b0;
    #0.5;
    begin item_t e; model_step(e); sb_q.push_back(e); end
    @(negedge clk); #1;
    hx = x_pos; hy = y_pos;
    chk(out_valid == 1'b1, "R5", "valid one cycle after iteration", 64'(out_valid), 64'd1);
    repeat (4) @(negedge clk);
    #1;
    chk(x_pos == hx && y_pos == hy, "R6", "held under back-pressure", {x_pos, y_pos}, {hx, hy});
    chk(out_valid == 1'b1, "R6", "valid held under back-pressure", 64'(out_valid), 64'd1);
    @(negedge clk);
    run_en = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R6", "stalled item delivered", 64'(sb_q.size()), 64'd0);

    // R7 run low: no movement, valid drops
    #1;
    hx = x_pos; hy = y_pos;
    repeat (5) @(negedge clk);
    #1;
    chk(x_pos == hx && y_pos == hy, "R7", "idle positions held", {x_pos, y_pos}, {hx, hy});
    chk(out_valid == 1'b0, "R7", "valid low when idle", 64'(out_valid), 64'd0);

    // R9 circle closes, random back-pressure
    do_load(100, 100, 512, 512, 0, 256, -16, 16);
    sx0 = 100; sy0 = 100; far_seen = 0; back_seen = 0; track_on = 1;
    run_iters(3000, 1);
    track_on = 0;
    chk(far_seen, "R9", "circle left start", 64'(far_seen), 64'd1);
    chk(back_seen, "R9", "circle returned near start", 64'(back_seen), 64'd1);

    // R10 hyperbola, random run and ready
    do_load(0, 0, 0, 0, 0, 64, 8, 8);
    run_iters(300, 2);
    #1;
    chk($signed(x_pos) > 18, "R10", "hyperbola x beyond line", 64'(x_pos), 64'd19);
    chk($signed(y_pos) > 0, "R10", "hyperbola y grows", 64'(y_pos), 64'd1);

    // R2 load wins over run in the same cycle
    @(negedge clk);
    run_en = 1'b1; out_ready = 1'b1;
    ld_x_pos = 16'd33; ld_y_pos = 16'd44; start_load = 1'b1;
    ld_x_frac = 10'd1000; ld_x_rate = 12'sd500;
    @(negedge clk);
    start_load = 1'b0; run_en = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R2", "load beats iteration valid", 64'(out_valid), 64'd0);
    chk(x_pos == 16'd33 && y_pos == 16'd44, "R2", "load beats iteration pos",
        {x_pos, y_pos}, {16'd33, 16'd44});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule